// File: doc/BRIEF.md
# Logic Self-Test Pattern Generator and Signature Compactor

This block is the datapath and sequencing of a logic self-test. A three-bit linear feedback shift register in external-XOR form drives a pseudo-random pattern to a circuit under test. The characteristic polynomial is 1 + x + x^3. The circuit's parallel response comes back every clock. A modular (internal-XOR) multiple-input signature register divides the combined response by the same polynomial and folds every output line into one signature. Because the register is linear, the final value equals the XOR of the remainders that each output line would have left on its own.

A run begins with a start request and a nonzero seed. One seeding cycle loads the generator with the seed and clears the compactor to zero, so no unknown value ever reaches the signature. A programmed number of pattern cycles follows. One compare cycle then checks the signature against a golden value supplied by the integrator. The pass and fail verdict is held until the next accepted start. Compaction loses information, so a faulty response can still produce the good signature. The pattern count is the knob that trades test time against that risk.

Top module: `lbist_engine`

## Requirements
- R1: While reset is low at a clock edge, the block returns to idle with pattern, signature, busy, done, pass and fail all zero.
- R2: The first pattern of a run equals the seed. Each pattern cycle produces next = {p[1]^p[0], p[2], p[1]}: the register shifts right and the XOR of bits 1 and 0 enters the MSB. From any nonzero seed the sequence has period 7.
- R3: The seeding cycle clears the signature to zero, whatever a previous run left there.
- R4: On each pattern cycle the signature becomes {s[1], s[0], 0} XOR (s[2] ? 3'b011 : 3'b000) XOR resp. In every other state the signature holds.
- R5: The final signature equals the XOR, over the three response lines, of the signature each line alone would produce.
- R6: An accepted start in idle or done gives exactly one seeding cycle, then pat_count pattern cycles, then one compare cycle, then done. busy is high in the seeding, pattern and compare states, and done is high only in the done state.
- R7: The compare cycle sets pass when the signature equals golden and sets fail otherwise. Pass and fail are never both high. Both are cleared when a start is accepted and are otherwise held.
- R8: A start with a seed of zero is ignored.
- R9: A pat_count of zero skips the pattern cycles, which leaves a signature of zero for the compare.
- R10: A start raised while a run is in progress has no effect on that run.
- R11: A stuck-at fault on a response line that changes the compacted stream gives a different signature and a fail verdict against the good golden value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a run (accepted in idle or done with a nonzero seed) |
| seed | input | WIDTH | Generator seed, loaded in the seeding cycle |
| pat_count | input | CNT_W | Number of pattern cycles, latched in the seeding cycle |
| golden | input | WIDTH | Expected good-machine signature |
| pattern | output | WIDTH | Stimulus to the circuit under test |
| cut_resp | input | WIDTH | Parallel response of the circuit under test |
| signature | output | WIDTH | Current compactor contents |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished, verdict valid |
| pass | output | 1 | Signature matched golden |
| fail | output | 1 | Signature differed from golden |

## Verification
The bench goes after runs that wrap past the generator period, a zero pattern count, a zero seed, and a start raised during a run. A design that advanced the generator one cycle too early or too late, or ran one pattern too many or too few, would show a shifted pattern stream and a different final signature. A design that failed to clear the compactor would carry the previous signature into the next run. A design that accepted a zero seed would lock the generator. A good and a faulty run are compared over five patterns. A compactor with the wrong feedback polynomial, or with a response bit entering at the wrong position, would break the superposition check or let the fault alias.

// File: rtl/lbist_pkg.sv
// Shared types for the logic self-test engine.
package lbist_pkg;
    // Run sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_RUN,
        ST_COMPARE,
        ST_DONE
    } bist_state_t;
endpackage

// File: rtl/lbist_prpg.sv
// Pseudo-random pattern generator, external-XOR form.
// The feedback is the XOR of the state bits selected by TAPS, shifted in at
// the MSB while the register moves right. Assumes WIDTH >= 2 and a nonzero
// seed; the all-zero state is a lock-up state that is never loaded.
module lbist_prpg #(
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] TAPS = 3'b011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] cur;
    logic             fb;

    // Feedback bit from the tapped positions.
    always_comb fb = ^(cur & TAPS);

    // Load the seed, or shift one position per pattern cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= '0;
        else if (load) cur <= seed;
        else if (step) cur <= {fb, cur[MSB:1]};
    end

    assign state_o = cur;

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cur != '0) |=> (cur != '0)); // R2
    AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cur)); // R2
endmodule

// File: rtl/lbist_misr.sv
// Multiple-input signature register, modular (internal-XOR) form.
// Each absorb cycle multiplies the state by x modulo the polynomial whose
// low coefficients are POLY, then XORs the parallel input in. A clear forces
// the state to zero so no unknown value is ever compacted.
module lbist_misr #(
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] POLY = 3'b011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             absorb,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sig_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sig;
    logic [WIDTH-1:0] nxt;

    // Per-bit next value: shifted-in neighbour, feedback tap, data input.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign nxt[i] = (sig[MSB] & POLY[i]) ^ din[i];
        end else begin : g_up
            assign nxt[i] = sig[i-1] ^ (sig[MSB] & POLY[i]) ^ din[i];
        end
    end

    // Clear before a run, absorb on pattern cycles, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      sig <= '0;
        else if (clear)  sig <= '0;
        else if (absorb) sig <= nxt;
    end

    assign sig_o = sig;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sig == '0)); // R3
    AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !absorb) |=> $stable(sig)); // R4
endmodule

// File: rtl/lbist_ctrl.sv
// Run sequencer and signature comparator.
// Accepts a start only in idle or done with a nonzero seed, spends one
// cycle seeding, pat_count cycles stepping, one cycle comparing, then holds
// the verdict until the next accepted start. Inputs are assumed stable
// from the start request until the seeding cycle ends.
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int WIDTH = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] seed,
    input  logic [CNT_W-1:0] pat_count,
    input  logic [WIDTH-1:0] signature,
    input  logic [WIDTH-1:0] golden,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             fail
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    bist_state_t      st, st_nxt;
    logic [CNT_W-1:0] remain;
    logic             accept;
    logic             pass_q, fail_q;

    // Start is honoured only when no run is active and the seed is usable.
    always_comb accept = (st == ST_IDLE || st == ST_DONE) && start && (seed != '0);

    // Next-state decode.
    always_comb begin
        st_nxt = st;
        case (st)
            ST_IDLE, ST_DONE: if (accept) st_nxt = ST_SEED;
            ST_SEED:    st_nxt = (pat_count == CNT_ZERO) ? ST_COMPARE : ST_RUN;
            ST_RUN:     if (remain == CNT_ONE) st_nxt = ST_COMPARE;
            ST_COMPARE: st_nxt = ST_DONE;
            default:    st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Pattern countdown, loaded while seeding.
    always_ff @(posedge clk) begin
        if (!rst_n)               remain <= '0;
        else if (st == ST_SEED)   remain <= pat_count;
        else if (st == ST_RUN)    remain <= remain - CNT_ONE;
    end

    // Verdict: cleared on acceptance, set by the compare cycle, else held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (accept) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (st == ST_COMPARE) begin
            pass_q <= (signature == golden);
            fail_q <= (signature != golden);
        end
    end

    assign load = (st == ST_SEED);
    assign step = (st == ST_RUN);
    assign busy = (st == ST_SEED) || (st == ST_RUN) || (st == ST_COMPARE);
    assign done = (st == ST_DONE);
    assign pass = pass_q;
    assign fail = fail_q;

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && fail_q)); // R7
    AST_RUN_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (remain != CNT_ZERO)); // R6
    AST_ZERO_SEED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && seed == '0) |=> (st == ST_IDLE)); // R8
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !accept) |=> ($stable(pass_q) && $stable(fail_q))); // R7
    AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |=> (st == ST_RUN || st == ST_COMPARE)); // R10
    AST_SEED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEED) |=> (st == ST_RUN || st == ST_COMPARE)); // R6
endmodule

// File: rtl/lbist_engine.sv
// Logic self-test engine: pattern generator, signature compactor and the
// sequencer/comparator that drives them. The circuit under test sits
// outside, between pattern and cut_resp, and must be combinational.
module lbist_engine #(
    parameter int WIDTH = 3,
    parameter int CNT_W = 16,
    parameter logic [WIDTH-1:0] GEN_TAPS  = 3'b011,
    parameter logic [WIDTH-1:0] MISR_POLY = 3'b011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] seed,
    input  logic [CNT_W-1:0] pat_count,
    input  logic [WIDTH-1:0] golden,
    output logic [WIDTH-1:0] pattern,
    input  logic [WIDTH-1:0] cut_resp,
    output logic [WIDTH-1:0] signature,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             fail
);
    logic load, step;

    lbist_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .pat_count(pat_count), .signature(signature), .golden(golden),
        .load(load), .step(step), .busy(busy), .done(done),
        .pass(pass), .fail(fail)
    );

    lbist_prpg #(.WIDTH(WIDTH), .TAPS(GEN_TAPS)) u_prpg (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .seed(seed), .state_o(pattern)
    );

    lbist_misr #(.WIDTH(WIDTH), .POLY(MISR_POLY)) u_misr (
        .clk(clk), .rst_n(rst_n), .clear(load), .absorb(step),
        .din(cut_resp), .sig_o(signature)
    );
endmodule

// File: tb/lbist_engine_test.sv
// Bench for lbist_engine: a behavioural model advanced on every rising edge
// and compared with all outputs on every falling edge.
module lbist_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  seed = 3'd0;
    logic [15:0] pat_count = 16'd0;
    logic [2:0]  golden = 3'd0;
    logic [2:0]  pattern, cut_resp, signature;
    logic        busy, done, pass, fail;
    logic        fault_on = 1'b0;
    logic        chk_en = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    // Model state codes (bench-local numbering).
    localparam int M_IDLE = 0, M_SEED = 1, M_RUN = 2, M_CMP = 3, M_DONE = 4;
    int ms = M_IDLE, mg = 0, mr = 0, mc = 0, mp = 0, mf = 0;

    always #2 clk = ~clk;

    // Combinational stand-in for the circuit under test; optional stuck-at-1 on line 0.
    function automatic logic [2:0] cut_fn(logic [2:0] p, logic f);
        logic [2:0] r;
        r[0] = f ? 1'b1 : ~p[1];
        r[1] = p[0] ^ p[2];
        r[2] = p[0] & p[1];
        return r;
    endfunction

    assign cut_resp = cut_fn(pattern, fault_on);

    lbist_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .pat_count(pat_count), .golden(golden), .pattern(pattern),
        .cut_resp(cut_resp), .signature(signature), .busy(busy),
        .done(done), .pass(pass), .fail(fail)
    );

    // Generator step as integer arithmetic: right shift, feedback bit1^bit0 into bit 2.
    function automatic int gen_int(int g);
        int fb;
        fb = ((g >> 1) ^ g) & 1;
        return (g >> 1) | (fb << 2);
    endfunction

    // Compactor step: multiply by x modulo 1+x+x^3, then add the input.
    function automatic int misr_int(int r, int d);
        int v;
        v = r * 2;
        if (v >= 8) v = (v - 8) ^ 3;
        return v ^ d;
    endfunction

    // Golden value built by superposition of each response line alone.
    function automatic int super_sig(int s, int n, logic f);
        int acc, g, r, rs;
        acc = 0;
        for (int j = 0; j < 3; j++) begin
            g = s;
            r = 0;
            for (int k = 0; k < n; k++) begin
                rs = int'(cut_fn(3'(g), f));
                r  = misr_int(r, rs & (1 << j));
                g  = gen_int(g);
            end
            acc = acc ^ r;
        end
        return acc;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = M_IDLE; mg = 0; mr = 0; mc = 0; mp = 0; mf = 0;
        end else begin
            case (ms)
                M_IDLE, M_DONE: if (start && seed != 0) begin
                    ms = M_SEED; mp = 0; mf = 0;
                end
                M_SEED: begin
                    mg = int'(seed); mr = 0; mc = int'(pat_count);
                    ms = (mc == 0) ? M_CMP : M_RUN;
                end
                M_RUN: begin
                    mr = misr_int(mr, int'(cut_fn(3'(mg), fault_on)));
                    mg = gen_int(mg);
                    mc = mc - 1;
                    if (mc == 0) ms = M_CMP;
                end
                M_CMP: begin
                    mp = (mr == int'(golden)) ? 1 : 0;
                    mf = 1 - mp;
                    ms = M_DONE;
                end
                default: ms = M_IDLE;
            endcase
        end
    end

    // Every-cycle comparison on the falling edge.
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R2 pattern", int'(pattern), mg);
            chk("R4 signature", int'(signature), mr);
            chk("R6 busy", int'(busy), (ms == M_SEED || ms == M_RUN || ms == M_CMP) ? 1 : 0);
            chk("R6 done", int'(done), (ms == M_DONE) ? 1 : 0);
            chk("R7 pass", int'(pass), mp);
            chk("R7 fail", int'(fail), mf);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic begin_run(int s, int n, int g, logic f);
        @(negedge clk);
        fault_on = f; seed = 3'(s); pat_count = 16'(n); golden = 3'(g); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R3 signature cleared after seeding", int'(signature), 0);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
        chk("R6 run reached done", int'(done), 1);
    endtask

    int g_good, g_bad, sig_good, sig_bad, p_save;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset pattern", int'(pattern), 0);
        chk("R1 reset signature", int'(signature), 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset pass/fail", int'({pass, fail}), 0);
        chk_en = 1'b1;

        // Good run, five patterns from seed 1.
        g_good = super_sig(1, 5, 1'b0);
        begin_run(1, 5, g_good, 1'b0);
        chk("R2 first pattern equals seed", int'(pattern), 1);
        @(negedge clk);
        chk("R2 second pattern", int'(pattern), 4);
        wait_done();
        sig_good = int'(signature);
        chk("R5 signature equals superposition", sig_good, g_good);
        chk("R7 good run passes", int'({pass, fail}), 2);

        // Same run with a stuck-at-1 on response line 0.
        begin_run(1, 5, g_good, 1'b1);
        wait_done();
        sig_bad = int'(signature);
        g_bad = super_sig(1, 5, 1'b1);
        chk("R11 faulty signature matches model", sig_bad, g_bad);
        chk("R11 fault changes signature", (sig_bad != sig_good) ? 1 : 0, 1);
        chk("R11 faulty run fails", int'({pass, fail}), 1);

        // Long run wrapping the period, other seed.
        g_good = super_sig(5, 20, 1'b0);
        begin_run(5, 20, g_good, 1'b0);
        wait_done();
        chk("R5 long run superposition", int'(signature), g_good);
        chk("R7 long run passes", int'(pass), 1);

        // Zero seed in done is ignored.
        p_save = int'(pass);
        @(negedge clk); seed = 3'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 zero seed keeps done", int'(done), 1);
        chk("R8 zero seed keeps verdict", int'(pass), p_save);

        // Zero pattern count.
        begin_run(3, 0, 0, 1'b0);
        wait_done();
        chk("R9 zero count signature", int'(signature), 0);
        chk("R9 zero count passes with golden 0", int'(pass), 1);
        begin_run(3, 0, 5, 1'b0);
        wait_done();
        chk("R9 zero count fails with golden 5", int'(fail), 1);

        // Start raised mid-run is ignored.
        g_good = super_sig(6, 30, 1'b0);
        begin_run(6, 30, g_good, 1'b0);
        repeat (4) @(negedge clk);
        seed = 3'd2; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        chk("R10 mid-run start has no effect", int'(signature), g_good);
        chk("R10 mid-run start verdict", int'(pass), 1);

        // Reset from done.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset after run clears done", int'(done), 0);
        chk("R1 reset after run clears signature", int'(signature), 0);

        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule